// File: doc/BRIEF.md
# Linear Frequency Sweep Accumulator

This block produces a frequency tuning word that ramps linearly from a programmed start word. A down counter, clocked by the sync clock, sets the interval between steps. The counter is loaded from a ramp-rate input. Each time the counter runs out, the step delta is added to an internal accumulator. The output word is the start word plus the accumulator, held at a programmed end word once the sweep reaches it.

An update strobe interacts with the sweep through two enables. One enable reloads the countdown, which restarts the current step interval. The other clears the accumulator for a single sync-clock period, after which the sweep resumes from the start word. A separate static clear-and-hold input keeps the accumulator at zero and the countdown at its reload value for as long as it is asserted. It overrides both strobe actions and stepping.

Top module: `freq_sweep_acc`

## Requirements
- R1: While reset is asserted and directly after its release, the accumulator is zero, the ramp counter is zero and `tuning_word` equals `start_word` (clipped to `end_word` as in R8).
- R2: With the ramp counter loaded with value N, the accumulator grows by `delta_word` once every N+1 sync-clock cycles. After k cycles from a hold release, `tuning_word` = `start_word` + `delta_word`·floor(k/(N+1)).
- R3: The ramp counter decrements by one each cycle and reloads from `ramp_rate` on the cycle after it reaches zero. When `reload_on_update` is 0, an `io_update` pulse does not alter the step timing.
- R4: When `reload_on_update` is 1, an `io_update` pulse loads `ramp_rate` into the counter at that edge. This restarts the current step, and the reload takes precedence over a step due on the same edge.
- R5: When `auto_clear` is 1, an `io_update` pulse sets the accumulator to zero for one cycle, so `tuning_word` equals `start_word`. Stepping then resumes on the unchanged counter schedule. A step due on the same edge is discarded.
- R6: When `auto_clear` is 0, an `io_update` pulse leaves the accumulator and `tuning_word` unchanged.
- R7: While `clear_hold` is 1, the accumulator stays at zero and the counter stays loaded with `ramp_rate`. After release, the first step arrives `ramp_rate`+1 cycles later.
- R8: `tuning_word` never exceeds `end_word`. Once `start_word` + accumulator reaches or passes `end_word`, the output equals `end_word` and the accumulator stops growing. If `start_word` ≥ `end_word`, the output is `end_word`.
- R9: `clear_hold` takes priority over `auto_clear`, over the countdown reload and over stepping. No step is taken while it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sync clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_word | input | FTW_W | Sweep start tuning word |
| delta_word | input | FTW_W | Increment added per step |
| end_word | input | FTW_W | Saturation limit of the output |
| ramp_rate | input | RR_W | Countdown reload value (step every ramp_rate+1 cycles) |
| io_update | input | 1 | Update strobe, one cycle per event |
| reload_on_update | input | 1 | Strobe restarts the step countdown |
| auto_clear | input | 1 | Strobe clears the accumulator for one cycle |
| clear_hold | input | 1 | Static clear-and-hold of accumulator and counter |
| tuning_word | output | FTW_W | Current swept tuning word |

## Verification
The main sweep runs over every ramp value from 0 to 3, each with deltas of 1, 3 and 7. These runs separate an off-by-one in the step interval from a wrong increment. Strobes are placed both between step edges and exactly on a step edge. This tells a reload or clear that merely delays a step apart from one that correctly overrides it. Short sweeps against a near end word, and a start word above the end word, expose overshoot past the limit. Combined hold-plus-strobe stimulus shows whether clear-and-hold dominates every other action.

// File: rtl/fsweep_pkg.sv
package fsweep_pkg;

  typedef enum logic [1:0] {
    CNT_DECR    = 2'd0,
    CNT_EXPIRE  = 2'd1,
    CNT_RESTART = 2'd2,
    CNT_HOLD    = 2'd3
  } cnt_op_e;

  typedef enum logic [1:0] {
    ACC_KEEP  = 2'd0,
    ACC_STEP  = 2'd1,
    ACC_PULSE = 2'd2,
    ACC_HOLD  = 2'd3
  } acc_op_e;

endpackage

// File: rtl/fsweep_ramp_counter.sv
module fsweep_ramp_counter #(
  parameter int RR_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RR_W-1:0] ramp_rate,
  input  logic            hold,
  input  logic            restart,
  output logic            step_tick,
  output logic [RR_W-1:0] cnt_q
);
  import fsweep_pkg::*;

  cnt_op_e op;
  logic    expired;

  assign expired = (cnt_q == '0);

  // hold dominates restart, restart dominates natural expiry
  always_comb begin
    if (hold)         op = CNT_HOLD;
    else if (restart) op = CNT_RESTART;
    else if (expired) op = CNT_EXPIRE;
    else              op = CNT_DECR;
  end

  assign step_tick = (op == CNT_EXPIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (op == CNT_DECR) cnt_q <= cnt_q - 1'b1;
    else                     cnt_q <= ramp_rate;
  end

endmodule

// File: rtl/fsweep_accum.sv
module fsweep_accum #(
  parameter int FTW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FTW_W-1:0] start_word,
  input  logic [FTW_W-1:0] delta_word,
  input  logic [FTW_W-1:0] end_word,
  input  logic             step,
  input  logic             clr_pulse,
  input  logic             clr_hold,
  output logic [FTW_W:0]   acc_q,
  output logic             at_end,
  output logic [FTW_W-1:0] word
);
  import fsweep_pkg::*;

  localparam int SUM_W = FTW_W + 2;

  function automatic logic [SUM_W-1:0] wide_sum(
    input logic [FTW_W-1:0] base,
    input logic [FTW_W:0]   acc
  );
    return SUM_W'(base) + SUM_W'(acc);
  endfunction

  function automatic logic [FTW_W-1:0] clip_word(
    input logic [SUM_W-1:0] sum,
    input logic [FTW_W-1:0] limit
  );
    return (sum >= SUM_W'(limit)) ? limit : sum[FTW_W-1:0];
  endfunction

  logic [SUM_W-1:0] sum;
  acc_op_e          op;

  assign sum    = wide_sum(start_word, acc_q);
  assign at_end = (sum >= SUM_W'(end_word));
  assign word   = clip_word(sum, end_word);

  always_comb begin
    if (clr_hold)           op = ACC_HOLD;
    else if (clr_pulse)     op = ACC_PULSE;
    else if (step && !at_end) op = ACC_STEP;
    else                    op = ACC_KEEP;
  end

  // acc_q stays below 2**FTW_W while stepping, so one extra bit absorbs a step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else begin
      unique case (op)
        ACC_HOLD, ACC_PULSE: acc_q <= '0;
        ACC_STEP:            acc_q <= acc_q + (FTW_W+1)'(delta_word);
        default:             acc_q <= acc_q;
      endcase
    end
  end

endmodule

// File: rtl/freq_sweep_acc.sv
module freq_sweep_acc #(
  parameter int FTW_W = 16,
  parameter int RR_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FTW_W-1:0] start_word,
  input  logic [FTW_W-1:0] delta_word,
  input  logic [FTW_W-1:0] end_word,
  input  logic [RR_W-1:0]  ramp_rate,
  input  logic             io_update,
  input  logic             reload_on_update,
  input  logic             auto_clear,
  input  logic             clear_hold,
  output logic [FTW_W-1:0] tuning_word
);

  // named internal events, visible to the bound checker
  logic            restart_evt;
  logic            pulse_clr_evt;
  logic            step_tick;
  logic            at_end;
  logic [RR_W-1:0] cnt_q;
  logic [FTW_W:0]  acc_q;

  assign restart_evt   = io_update & reload_on_update;
  assign pulse_clr_evt = io_update & auto_clear;

  fsweep_ramp_counter #(.RR_W(RR_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .ramp_rate (ramp_rate),
    .hold      (clear_hold),
    .restart   (restart_evt),
    .step_tick (step_tick),
    .cnt_q     (cnt_q)
  );

  fsweep_accum #(.FTW_W(FTW_W)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_word (start_word),
    .delta_word (delta_word),
    .end_word   (end_word),
    .step       (step_tick),
    .clr_pulse  (pulse_clr_evt),
    .clr_hold   (clear_hold),
    .acc_q      (acc_q),
    .at_end     (at_end),
    .word       (tuning_word)
  );

endmodule

// File: rtl/freq_sweep_acc_chk.sv
module freq_sweep_acc_chk #(
  parameter int FTW_W = 16,
  parameter int RR_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [FTW_W-1:0] delta_word,
  input logic [RR_W-1:0]  ramp_rate,
  input logic             io_update,
  input logic             reload_on_update,
  input logic             auto_clear,
  input logic             clear_hold,
  input logic             step_tick,
  input logic             at_end,
  input logic [RR_W-1:0]  cnt_q,
  input logic [FTW_W:0]   acc_q
);

  p_step_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_tick && !clear_hold && !(io_update && auto_clear) && !at_end
    |=> acc_q == $past(acc_q) + (FTW_W+1)'($past(delta_word)));

  p_expire_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |=> cnt_q == $past(ramp_rate));

  p_countdown_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) && !clear_hold && !(io_update && reload_on_update)
    |=> cnt_q == $past(cnt_q) - 1'b1);

  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    io_update && reload_on_update |=> cnt_q == $past(ramp_rate));

  p_pulse_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    io_update && auto_clear |=> acc_q == '0);

  p_update_inert_r6: assert property (@(posedge clk) disable iff (!rst_n)
    io_update && !auto_clear && !clear_hold && !step_tick |=> $stable(acc_q));

  p_hold_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_hold |=> acc_q == '0 && cnt_q == $past(ramp_rate));

  p_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    at_end && !clear_hold && !(io_update && auto_clear) |=> $stable(acc_q));

  p_hold_no_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_hold |-> !step_tick);

endmodule

bind freq_sweep_acc freq_sweep_acc_chk #(.FTW_W(FTW_W), .RR_W(RR_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .delta_word       (delta_word),
  .ramp_rate        (ramp_rate),
  .io_update        (io_update),
  .reload_on_update (reload_on_update),
  .auto_clear       (auto_clear),
  .clear_hold       (clear_hold),
  .step_tick        (step_tick),
  .at_end           (at_end),
  .cnt_q            (cnt_q),
  .acc_q            (acc_q)
);

// File: tb/freq_sweep_acc_tb.sv
module freq_sweep_acc_tb;
  localparam int W  = 16;
  localparam int RW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [W-1:0]  start_word, delta_word, end_word;
  logic [RW-1:0] ramp_rate;
  logic          io_update, reload_on_update, auto_clear, clear_hold;
  logic [W-1:0]  tuning_word;

  always #10 clk = ~clk;

  freq_sweep_acc #(.FTW_W(W), .RR_W(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_word(start_word), .delta_word(delta_word),
    .end_word(end_word), .ramp_rate(ramp_rate), .io_update(io_update),
    .reload_on_update(reload_on_update), .auto_clear(auto_clear),
    .clear_hold(clear_hold), .tuning_word(tuning_word)
  );

  int n_vec = 0;
  int n_bad = 0;
  int k;
  int m;
  int rr;
  longint cs, cd, ce;

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic check(string tag, longint got, longint exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (k=%0d)", tag, got, exp, k);
    end
  endtask

  function automatic longint model(int steps);
    longint v = cs + cd * steps;
    return (v >= ce) ? ce : v;
  endfunction

  // one hold edge loads the counter with r; k counts edges since release
  task automatic setup(int r, longint s, longint d, longint e);
    rr = r; cs = s; cd = d; ce = e;
    ramp_rate = RW'(r); start_word = W'(s); delta_word = W'(d); end_word = W'(e);
    io_update = 0; auto_clear = 0; reload_on_update = 0; clear_hold = 1;
    @(negedge clk);
    clear_hold = 0;
    k = 0;
  endtask

  task automatic adv();
    @(negedge clk);
    k++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    rst_n = 0; io_update = 0; auto_clear = 0; reload_on_update = 0; clear_hold = 0;
    start_word = 16'h0123; delta_word = 16'd4; end_word = 16'hFFFF; ramp_rate = 8'd2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 reset word", tuning_word, 16'h0123);

    // R2: exhaustive over ramp values 0..3 and three deltas
    for (int r = 0; r < 4; r++) begin
      for (int di = 0; di < 3; di++) begin
        setup(r, 'h100, (di == 0) ? 1 : (di == 1) ? 3 : 7, 'hFFFF);
        check("R2 start", tuning_word, model(0));
        for (int i = 0; i < 12; i++) begin
          adv();
          check("R2 sweep", tuning_word, model(k / (r + 1)));
        end
      end
    end

    // R8: saturation near the end word, and start above end
    setup(1, 100, 5, 117);
    for (int i = 0; i < 20; i++) begin
      adv();
      check("R8 clip", tuning_word, model(k / 2));
    end
    setup(0, 500, 9, 400);
    for (int i = 0; i < 5; i++) begin
      adv();
      check("R8 start above end", tuning_word, 400);
    end

    // R3 R6: strobe with both enables off changes nothing
    setup(3, 'h40, 2, 'hFFFF);
    adv(); adv();
    io_update = 1; adv(); io_update = 0;
    for (int i = 0; i < 10; i++) begin
      check("R3 R6 inert strobe", tuning_word, model(k / 4));
      adv();
    end

    // R4: restart between steps (edge 2) and on a step edge (edge 4)
    for (int pass = 0; pass < 2; pass++) begin
      setup(3, 'h40, 2, 'hFFFF);
      reload_on_update = 1;
      repeat (pass == 0 ? 1 : 3) adv();
      io_update = 1; adv(); io_update = 0;
      m = k;
      for (int i = 0; i < 12; i++) begin
        check("R4 restart", tuning_word, model((m - 1) / 4 + (k - m) / 4));
        adv();
      end
      reload_on_update = 0;
    end

    // R5: auto-clear between steps (edge 6) and on a step edge (edge 8)
    for (int pass = 0; pass < 2; pass++) begin
      setup(3, 'h40, 2, 'hFFFF);
      auto_clear = 1;
      repeat (pass == 0 ? 5 : 7) adv();
      io_update = 1; adv(); io_update = 0;
      m = k;
      check("R5 cleared cycle", tuning_word, 'h40);
      for (int i = 0; i < 10; i++) begin
        adv();
        check("R5 resume", tuning_word, model(k / 4 - m / 4));
      end
      auto_clear = 0;
    end

    // R7: hold mid-sweep, then restart timing after release
    setup(1, 'h40, 3, 'hFFFF);
    repeat (5) adv();
    check("R7 before hold", tuning_word, model(2));
    clear_hold = 1;
    for (int i = 0; i < 3; i++) begin
      adv();
      check("R7 held", tuning_word, 'h40);
    end
    clear_hold = 0; k = 0;
    for (int i = 0; i < 6; i++) begin
      adv();
      check("R7 after release", tuning_word, model(k / 2));
    end

    // R9: hold with every strobe action enabled
    setup(1, 'h40, 3, 'hFFFF);
    repeat (3) adv();
    clear_hold = 1; io_update = 1; auto_clear = 1; reload_on_update = 1;
    adv(); check("R9 hold wins", tuning_word, 'h40);
    adv(); check("R9 hold wins", tuning_word, 'h40);
    clear_hold = 0; io_update = 0; auto_clear = 0; reload_on_update = 0; k = 0;
    for (int i = 0; i < 4; i++) begin
      adv();
      check("R9 after hold", tuning_word, model(k / 2));
    end

    report();
  end

endmodule